// File: doc/BRIEF.md
# One-Hot Iterative-Loop Controller

This block sequences a small datapath that loads two operands, replaces the second by its absolute value, then repeatedly increments the first and decrements the second while a comparison flag says the first is still smaller, and finally hands off for an output stage. Each of the six control steps (wait, setup, absolute, check, iterate, finish) owns a single D flip-flop, so exactly one flip-flop carries the active token at any time.

The two branch points are one-to-two demultiplexers. In the wait step the start request routes the token either to setup or back to wait. In the check step the comparison flag routes it to iterate or to finish. All other steps pass the token on unconditionally. Load enables and operand selects are ORs of state flip-flops, so they depend on the current step only. A one-hot monitor raises an error output whenever the count of set flip-flops differs from one.

Top module: `iterloop_onehot_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, the wait step is active, so `ld_x_o`, `ld_y_o`, `sel_x_o` and `sel_y_o` are all 0.
- R2: While in the wait step with `start_i` = 0 and no clear, the block stays in the wait step, with all loads and selects at 0.
- R3: A clock edge in the wait step with `start_i` = 1 enters setup: `ld_x_o` = 1, `ld_y_o` = 1, `sel_x_o` = 0 (external input), `sel_y_o` = 2'b00 (external input).
- R4: Setup is always followed by the absolute step: `ld_y_o` = 1, `ld_x_o` = 0, `sel_x_o` = 0, `sel_y_o` = 2'b10 (absolute value of y).
- R5: The absolute step is always followed by the check step, in which all loads and selects are 0.
- R6: A clock edge in the check step with `k_i` = 1 enters iterate: `ld_x_o` = 1, `ld_y_o` = 1, `sel_x_o` = 1 (incremented x), `sel_y_o` = 2'b01 (decremented y); iterate is always followed by the check step.
- R7: A clock edge in the check step with `k_i` = 0 enters the finish step, with all loads and selects at 0; the finish step is always followed by the wait step.
- R8: A synchronous `clr_i` = 1 at a clock edge puts the block in the wait step from any step, overriding `start_i` and `k_i`.
- R9: Exactly one state flip-flop is set in every cycle, and `onehot_err_o` is 0 whenever that holds.
- R10: `start_i` has no effect outside the wait step, and `k_i` has no effect outside the check step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset to the wait step |
| clr_i | input | 1 | Synchronous clear to the wait step |
| start_i | input | 1 | Start request, sampled in the wait step |
| k_i | input | 1 | Comparison flag (x less than y), sampled in the check step |
| ld_x_o | output | 1 | Load enable for the x register |
| ld_y_o | output | 1 | Load enable for the y register |
| sel_x_o | output | 1 | x source: 0 external, 1 incremented |
| sel_y_o | output | 2 | y source: 00 external, 01 decremented, 10 absolute |
| onehot_err_o | output | 1 | High when the state vector is not one-hot |

## Verification
The assertions watch the token every cycle: that the state vector stays one-hot with the error flag low, that each unconditional hop and each demultiplexer branch lands on the right successor, that clear always lands in wait, and that setup drives both loads with external selects. What the assertions cannot show is the full control word produced in long mixed runs, where start and the comparison flag toggle at random while the token is elsewhere; the bench tracks its own copy of the step sequence and compares all five control outputs each cycle, including right after clears and after start pulses that arrive mid-loop.

// File: rtl/iterloop_pkg.sv
package iterloop_pkg;
  localparam int unsigned NUM_ST = 6;
  localparam int unsigned ST_WAIT  = 0;
  localparam int unsigned ST_SETUP = 1;
  localparam int unsigned ST_ABS   = 2;
  localparam int unsigned ST_CHK   = 3;
  localparam int unsigned ST_ITER  = 4;
  localparam int unsigned ST_MUL   = 5;

  localparam int unsigned SELY_W = 2;
  localparam logic [SELY_W-1:0] SELY_EXT = 2'b00;
  localparam logic [SELY_W-1:0] SELY_DEC = 2'b01;
  localparam logic [SELY_W-1:0] SELY_ABS = 2'b10;

  function automatic int unsigned pop_count(input logic [NUM_ST-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < NUM_ST; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/iterloop_state_ff.sv
module iterloop_state_ff #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (clr_i) q_o <= RST_VAL;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/iterloop_demux2.sv
module iterloop_demux2 (
  input  logic tok_i,
  input  logic sel_i,
  output logic out0_o,
  output logic out1_o
);
  assign out0_o = tok_i & ~sel_i;
  assign out1_o = tok_i &  sel_i;
endmodule

// File: rtl/iterloop_out_dec.sv
module iterloop_out_dec
  import iterloop_pkg::*;
(
  input  logic [NUM_ST-1:0] st_i,
  output logic              ld_x_o,
  output logic              ld_y_o,
  output logic              sel_x_o,
  output logic [SELY_W-1:0] sel_y_o
);
  always_comb begin
    ld_x_o  = st_i[ST_SETUP] | st_i[ST_ITER];
    ld_y_o  = st_i[ST_SETUP] | st_i[ST_ABS] | st_i[ST_ITER];
    sel_x_o = st_i[ST_ITER];
    sel_y_o = SELY_EXT;
    if (st_i[ST_ABS])  sel_y_o = sel_y_o | SELY_ABS;
    if (st_i[ST_ITER]) sel_y_o = sel_y_o | SELY_DEC;
  end
endmodule

// File: rtl/iterloop_onehot_ctrl.sv
module iterloop_onehot_ctrl
  import iterloop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       start_i,
  input  logic       k_i,
  output logic       ld_x_o,
  output logic       ld_y_o,
  output logic       sel_x_o,
  output logic [1:0] sel_y_o,
  output logic       onehot_err_o
);
  logic [NUM_ST-1:0] st_q;
  logic [NUM_ST-1:0] st_d;
  logic wait_stay, wait_go, chk_mul, chk_iter;

  iterloop_demux2 u_dmx_start (
    .tok_i (st_q[ST_WAIT]),
    .sel_i (start_i),
    .out0_o(wait_stay),
    .out1_o(wait_go)
  );

  iterloop_demux2 u_dmx_k (
    .tok_i (st_q[ST_CHK]),
    .sel_i (k_i),
    .out0_o(chk_mul),
    .out1_o(chk_iter)
  );

  always_comb begin
    st_d           = '0;
    st_d[ST_WAIT]  = wait_stay | st_q[ST_MUL];
    st_d[ST_SETUP] = wait_go;
    st_d[ST_ABS]   = st_q[ST_SETUP];
    st_d[ST_CHK]   = st_q[ST_ABS] | st_q[ST_ITER];
    st_d[ST_ITER]  = chk_iter;
    st_d[ST_MUL]   = chk_mul;
  end

  for (genvar i = 0; i < NUM_ST; i++) begin : g_st
    iterloop_state_ff #(.RST_VAL(i == ST_WAIT)) u_ff (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_i),
      .d_i   (st_d[i]),
      .q_o   (st_q[i])
    );
  end

  iterloop_out_dec u_dec (
    .st_i   (st_q),
    .ld_x_o (ld_x_o),
    .ld_y_o (ld_y_o),
    .sel_x_o(sel_x_o),
    .sel_y_o(sel_y_o)
  );

  assign onehot_err_o = (pop_count(st_q) != 1);

  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(st_q) == 1) && !onehot_err_o);

  p_hold_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[ST_WAIT] && !start_i && !clr_i) |=> st_q[ST_WAIT]);

  p_setup_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q[ST_SETUP] |-> (ld_x_o && ld_y_o && !sel_x_o && sel_y_o == SELY_EXT));

  p_abs_after_setup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[ST_SETUP] && !clr_i) |=> (st_q[ST_ABS] && ld_y_o && !ld_x_o));

  p_iter_on_k_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[ST_CHK] && k_i && !clr_i) |=> (st_q[ST_ITER] && sel_x_o));

  p_mul_on_nk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[ST_CHK] && !k_i && !clr_i) |=> (st_q[ST_MUL] && !ld_x_o && !ld_y_o));

  p_clr_to_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (st_q[ST_WAIT] && !ld_x_o && !ld_y_o));
endmodule

// File: tb/iterloop_onehot_ctrl_bench.sv
module iterloop_onehot_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_CYCLES   = 3000;

  typedef enum int {M_WAIT, M_SETUP, M_ABS, M_CHK, M_ITER, M_MUL} mst_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, start = 1'b0, k = 1'b0;
  logic ld_x, ld_y, sel_x, err;
  logic [1:0] sel_y;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iterloop_onehot_ctrl u_iterloop_onehot_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .start_i(start), .k_i(k),
    .ld_x_o(ld_x), .ld_y_o(ld_y), .sel_x_o(sel_x), .sel_y_o(sel_y),
    .onehot_err_o(err)
  );

  // {ld_x, ld_y, sel_x, sel_y[1:0], err}
  function automatic logic [5:0] exp_word(mst_t s);
    case (s)
      M_SETUP: return 6'b11_0_00_0;
      M_ABS:   return 6'b01_0_10_0;
      M_ITER:  return 6'b11_1_01_0;
      default: return 6'b00_0_00_0;
    endcase
  endfunction

  function automatic mst_t next_st(mst_t s, logic c, logic st, logic kk);
    if (c) return M_WAIT;
    case (s)
      M_WAIT:  return st ? M_SETUP : M_WAIT;
      M_SETUP: return M_ABS;
      M_ABS:   return M_CHK;
      M_CHK:   return kk ? M_ITER : M_MUL;
      M_ITER:  return M_CHK;
      default: return M_WAIT;
    endcase
  endfunction

  function automatic string tag_for(mst_t s);
    case (s)
      M_WAIT:  return "R2";
      M_SETUP: return "R3";
      M_ABS:   return "R4";
      M_CHK:   return "R5";
      M_ITER:  return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, mst_t s);
    logic [5:0] act = {ld_x, ld_y, sel_x, sel_y, err};
    logic [5:0] exp = exp_word(s);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s state=%0d actual=%b expected=%b (R9 err bit last)", tag, s, act, exp);
    end
  endtask

  mst_t ms = M_WAIT;

  // Drive at negedge, check before driving; returns after the next negedge.
  task automatic step(logic c, logic st, logic kk, string force_tag);
    mst_t nx;
    clr = c; start = st; k = kk;
    nx = next_st(ms, c, st, kk);
    @(negedge clk);
    ms = nx;
    check((force_tag != "") ? force_tag : tag_for(ms), ms);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", M_WAIT);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", M_WAIT);

    // Directed: hold, start, two iterations, finish, back to wait
    step(0, 0, 1, "R2");
    step(0, 1, 0, "R3");
    step(0, 1, 0, "R10");   // start in setup ignored -> abs
    step(0, 0, 0, "R5");    // abs -> chk
    step(0, 1, 1, "R6");    // chk,k=1 -> iter
    step(0, 0, 0, "R10");   // k ignored in iter -> chk
    step(0, 0, 1, "R6");
    step(0, 0, 0, "R6");    // iter -> chk
    step(0, 1, 0, "R7");    // chk,k=0 -> mul (start ignored)
    step(0, 1, 1, "R7");    // mul -> wait regardless
    step(0, 0, 0, "R2");
    // Clear in mid-loop
    step(0, 1, 0, "R3");
    step(0, 0, 0, "R4");
    step(1, 1, 1, "R8");
    step(0, 0, 0, "R2");

    for (int i = 0; i < N_CYCLES; i++) begin
      logic c  = ($urandom_range(0, 39) == 0);
      logic st = ($urandom_range(0, 3) == 0);
      logic kk = ($urandom_range(0, 9) < 7);
      string t = "";
      if (c) t = "R8";
      else if (st && ms != M_WAIT) t = "R10";
      step(c, st, kk, t);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule